// File: doc/BRIEF.md
# Serial Port Bit-Rate Generator

This block derives the bit clock of a synchronous serial or card port from the port's input clock. A single 32-bit timing word sets the bit rate through two cascaded stages. The first is an even pre-divider. The second is a rate counter that counts the pre-divider's output pulses. Together they divide the input clock by DIVIDE × (1 + RATE). The generator gives a clock level with an exact 50% duty cycle and a one-cycle enable pulse once per bit period, which the shifting logic of the port can use.

The same timing word also holds a data timeout value. While the port waits for data, a down-counter steps once every 4096 input clocks. When it reaches zero, a sticky expired flag is raised. Writing the timing word restarts both divider stages from zero, so a new rate takes effect from a known phase.

Top module: `bitrate_gen`

## Requirements
- R1: After reset, bitClk, bitTick and timeoutHit are 0, and the timing word is zero. The block therefore runs at the minimum divide of 2 with a rate of 0, and the timeout is disabled.
- R2: The timing word is laid out as {timeout[31:16], divide[15:8], rate[7:0]}. The bit period is D × (1 + rate) input clocks. D is the divide field with its bit 0 treated as 0, and a value below 2 is used as 2.
- R3: bitClk toggles every D × (1 + rate) / 2 input clocks, so it is high and low for equal times.
- R4: bitTick is high for exactly one cycle per bit period, namely the cycle in which bitClk has just risen.
- R5: At the clock edge that samples timingWe high, both divider stages clear and bitClk and bitTick go to 0. The first rise of bitClk then follows D × (1 + rate) / 2 clocks later.
- R6: While waitData is high and the timeout field T is non-zero, timeoutHit rises after T × 4096 consecutive clocks with waitData high, and it then stays high.
- R7: A clock edge with waitData low reloads the timeout counter from the field and clears timeoutHit. A write to the timing word has the same effect.
- R8: A timeout field of 0 disables the timeout: timeoutHit stays 0 however long waitData is high.
- R9: An odd divide field gives the same bit period as the even value just below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input port clock |
| rstN | input | 1 | Active-low synchronous reset |
| timingWe | input | 1 | Write strobe for the timing word |
| timingWdata | input | 32 | New timing word {timeout, divide, rate} |
| waitData | input | 1 | High while the port waits for data; runs the timeout |
| bitClk | output | 1 | Divided bit clock level, 50% duty |
| bitTick | output | 1 | One-cycle pulse on each rise of bitClk |
| timeoutHit | output | 1 | Sticky data-timeout expired flag |

## Verification
All three outputs are registered, so each result appears one edge after the edge that causes it. A write clears bitClk and bitTick at that same edge, and the k-th toggle comes k × D × (1 + rate) / 2 edges after the write. timeoutHit rises on the T × 4096-th edge that sees waitData high. The bench steps a behavioural model at every rising edge from the same inputs. It compares the model with the outputs at the following falling edge, so each comparison sees exactly the edge count that the requirement states. Extra explicit checks are placed one falling edge after a write, at the end of long waits, and after waitData drops.

// File: rtl/bitrate_pkg.sv
package bitrate_pkg;
  localparam int RATE_W = 8;
  localparam int DIV_W  = 8;
  localparam int TO_W   = 16;
  localparam int REG_W  = TO_W + DIV_W + RATE_W;
  localparam int HALF_W = DIV_W - 1;

  // Control to datapath: one restart strobe plus the decoded stage limits.
  typedef struct packed {
    logic              restart;
    logic [HALF_W-1:0] halfDiv;
    logic [RATE_W-1:0] rateMax;
  } bitrate_strobe_t;
endpackage

// File: rtl/bitrate_ctrl.sv
module bitrate_ctrl
  import bitrate_pkg::*;
#(
  parameter int PRESCALE_LOG2 = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             timingWe,
  input  logic [REG_W-1:0] timingWdata,
  input  logic             waitData,
  output bitrate_strobe_t  strobe,
  output logic             timeoutHit
);
  localparam int TO_LSB  = RATE_W + DIV_W;
  localparam int DIV_LSB = RATE_W + 1;

  logic [REG_W-1:0]         timingReg;
  logic [HALF_W-1:0]        divUpper;
  logic [TO_W-1:0]          toField;
  logic [PRESCALE_LOG2-1:0] prescale;
  logic [TO_W-1:0]          toCnt;

  always_ff @(posedge clk) begin
    if (!rstN)         timingReg <= '0;
    else if (timingWe) timingReg <= timingWdata;
  end

  // Bit 0 of the divide field is dropped, so the divide is always even.
  assign divUpper = timingReg[DIV_LSB +: HALF_W];
  assign toField  = timingReg[TO_LSB +: TO_W];

  always_comb begin
    strobe.restart = timingWe;
    strobe.halfDiv = (divUpper == '0) ? HALF_W'(1) : divUpper;
    strobe.rateMax = timingReg[0 +: RATE_W];
  end

  // Timeout: prescaler of 2^PRESCALE_LOG2 clocks feeding a down-counter.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescale   <= '0;
      toCnt      <= '0;
      timeoutHit <= 1'b0;
    end else if (timingWe) begin
      prescale   <= '0;
      toCnt      <= timingWdata[TO_LSB +: TO_W];
      timeoutHit <= 1'b0;
    end else if (!waitData) begin
      prescale   <= '0;
      toCnt      <= toField;
      timeoutHit <= 1'b0;
    end else if (toField != '0 && toCnt != '0) begin
      prescale <= prescale + PRESCALE_LOG2'(1);
      if (&prescale) begin
        toCnt <= toCnt - TO_W'(1);
        if (toCnt == TO_W'(1)) timeoutHit <= 1'b1;
      end
    end
  end

  // R8: a zero timeout field never lets the flag rise.
  a_r8_disabled_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    (toField == '0) |-> !timeoutHit);
  // R7: waitData low clears the flag at the next edge.
  a_r7_wait_low_clears: assert property (@(posedge clk) disable iff (!rstN)
    !waitData |=> !timeoutHit);
  // R6: the flag only stands once the counter is exhausted.
  a_r6_hit_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    timeoutHit |-> (toCnt == '0));
endmodule

// File: rtl/bitrate_dp.sv
module bitrate_dp
  import bitrate_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  bitrate_strobe_t strobe,
  output logic            bitClk,
  output logic            bitTick
);
  logic [HALF_W-1:0] preCnt;
  logic [RATE_W-1:0] rateCnt;
  logic              preWrap;
  logic              rateWrap;

  assign preWrap  = (preCnt == strobe.halfDiv - HALF_W'(1));
  assign rateWrap = (rateCnt == strobe.rateMax);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) begin
      preCnt  <= '0;
      rateCnt <= '0;
      bitClk  <= 1'b0;
      bitTick <= 1'b0;
    end else begin
      bitTick <= 1'b0;
      if (preWrap) begin
        preCnt <= '0;
        if (rateWrap) begin
          rateCnt <= '0;
          bitClk  <= ~bitClk;
          bitTick <= ~bitClk;
        end else begin
          rateCnt <= rateCnt + RATE_W'(1);
        end
      end else begin
        preCnt <= preCnt + HALF_W'(1);
      end
    end
  end

  // R2: the pre-divider never passes its programmed limit.
  a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rstN)
    preCnt < strobe.halfDiv);
  // R4: a tick only comes with a fresh rise of the clock level.
  a_r4_tick_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> (bitClk && !$past(bitClk)));
  // R5: a write leaves the outputs low on the following cycle.
  a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (!bitClk && !bitTick));
endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen
  import bitrate_pkg::*;
#(
  parameter int PRESCALE_LOG2 = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             timingWe,
  input  logic [REG_W-1:0] timingWdata,
  input  logic             waitData,
  output logic             bitClk,
  output logic             bitTick,
  output logic             timeoutHit
);
  bitrate_strobe_t strobe;

  bitrate_ctrl #(.PRESCALE_LOG2(PRESCALE_LOG2)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .timingWe    (timingWe),
    .timingWdata (timingWdata),
    .waitData    (waitData),
    .strobe      (strobe),
    .timeoutHit  (timeoutHit)
  );

  bitrate_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .bitClk  (bitClk),
    .bitTick (bitTick)
  );
endmodule

// File: tb/bitrate_gen_tb.sv
module bitrate_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        timingWe = 1'b0;
  logic [31:0] timingWdata = '0;
  logic        waitData = 1'b0;
  logic        bitClk, bitTick, timeoutHit;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  string curReq = "R1";

  // Behavioural model state.
  int mHalf = 1, mCnt = 0, mWait = 0, mT = 0;
  bit mClk = 0, mTick = 0, mHit = 0;

  always #2.5 clk = ~clk;

  bitrate_gen u_dut (
    .clk(clk), .rstN(rstN), .timingWe(timingWe), .timingWdata(timingWdata),
    .waitData(waitData), .bitClk(bitClk), .bitTick(bitTick), .timeoutHit(timeoutHit)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mHalf = 1; mCnt = 0; mClk = 0; mTick = 0; mWait = 0; mHit = 0; mT = 0;
    end else if (timingWe) begin
      int d;
      d = int'(timingWdata[15:8]) & 32'hFE;
      if (d < 2) d = 2;
      mHalf = (d / 2) * (int'(timingWdata[7:0]) + 1);
      mT = int'(timingWdata[31:16]);
      mCnt = 0; mClk = 0; mTick = 0; mWait = 0; mHit = 0;
    end else begin
      mCnt++;
      mTick = 0;
      if (mCnt == mHalf) begin
        mCnt = 0;
        mClk = !mClk;
        mTick = mClk;
      end
      if (!waitData) begin
        mWait = 0; mHit = 0;
      end else if (mT != 0) begin
        mWait++;
        if (mWait == mT * 4096) mHit = 1;
      end
    end
  end

  task automatic checkVal(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      checkVal(curReq, "bitClk", bitClk, mClk);
      checkVal("R4", "bitTick", bitTick, mTick);
      checkVal("R6", "timeoutHit", timeoutHit, mHit);
    end
  end

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 200000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<200000", cycles);
      finishRun();
    end
  end

  task automatic writeTiming(int t, int div, int rate);
    @(negedge clk);
    timingWe = 1'b1;
    timingWdata = {t[15:0], div[7:0], rate[7:0]};
    @(negedge clk);
    timingWe = 1'b0;
  endtask

  task automatic runCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    runCycles(3);
    checkVal("R1", "bitClk reset", bitClk, 1'b0);
    checkVal("R1", "bitTick reset", bitTick, 1'b0);
    checkVal("R1", "timeoutHit reset", timeoutHit, 1'b0);
    rstN = 1'b1;
    curReq = "R1";
    runCycles(20);

    curReq = "R2";
    writeTiming(0, 4, 2);
    runCycles(100);
    curReq = "R3";
    writeTiming(0, 12, 0);
    runCycles(80);

    curReq = "R9";
    writeTiming(0, 11, 1);
    runCycles(120);

    curReq = "R2";
    writeTiming(0, 1, 5);
    runCycles(60);

    curReq = "R5";
    writeTiming(0, 6, 3);
    runCycles(15);
    checkVal("R5", "bitClk high mid-period", bitClk, 1'b1);
    @(negedge clk);
    timingWe = 1'b1;
    timingWdata = {16'd0, 8'd6, 8'd3};
    @(negedge clk);
    timingWe = 1'b0;
    checkVal("R5", "bitClk after write", bitClk, 1'b0);
    checkVal("R5", "bitTick after write", bitTick, 1'b0);
    runCycles(50);

    curReq = "R2";
    writeTiming(0, 254, 255);
    runCycles(66000);

    curReq = "R6";
    writeTiming(2, 2, 0);
    waitData = 1'b1;
    runCycles(8300);
    checkVal("R6", "timeoutHit after 2x4096", timeoutHit, 1'b1);
    waitData = 1'b0;
    @(negedge clk);
    checkVal("R7", "timeoutHit after wait low", timeoutHit, 1'b0);
    waitData = 1'b1;
    runCycles(5000);
    checkVal("R7", "timeoutHit after reload", timeoutHit, 1'b0);
    runCycles(3300);
    checkVal("R6", "timeoutHit second expiry", timeoutHit, 1'b1);

    writeTiming(0, 2, 0);
    runCycles(10000);
    checkVal("R8", "timeoutHit disabled", timeoutHit, 1'b0);
    waitData = 1'b0;
    runCycles(5);
    finishRun();
  end
endmodule